// File: doc/BRIEF.md
# Coprocessor Instruction Handshake Controller

This block sits on the coprocessor side of a link between a RISC integer unit and a floating-point unit. The integer unit places an instruction on a shared 32-bit bus with an instruction strobe. One stage later it places that instruction's address on the same bus with an address strobe. The controller pairs the two and holds them in matching instruction and address queues, which are two entries deep by default. An end strobe from the host pipeline retires the oldest pair once its work is finished.

While the address of a new operate instruction arrives, the controller compares the instruction's source register fields with the destinations of queued operations that are still running. On a match it pulls an active-low hold and keeps it low until the producer finishes. The arithmetic datapath is modelled as a fixed-latency busy counter. At completion it samples an exception input and a condition-code input. A recorded exception is reported through an active-low request only when a floating-point instruction is on the bus. The request then stays low until the host acknowledges it. The condition codes come with a valid flag that is low while a compare is outstanding. A flush input clears all queued and pending state in one cycle.

Instruction encoding: bits [31:30] give the class (00 not floating-point, 01 branch, 10 operate, 11 load/store). For operates, bits [29:26] give the opcode (0 means compare, which writes no register), bits [25:21] the destination, bits [20:16] the first source and bits [15:11] the second source.

Top module: `fpc_handshake`

## Requirements
- R1: After reset, hold_n, exc_req_n and cc_valid are 1, cc is 00 and head_valid is 0.
- R2: An instruction taken with ins_strobe and the bus word taken with a later adr_strobe form one queue entry. head_addr shows the address of the oldest entry, and a second entry waits behind it without changing head_addr.
- R3: end_strobe retires the head entry only when the head's operation has completed. An end_strobe while the head operate is still executing leaves head_addr and head_valid unchanged.
- R4: An address strobe that arrives while the queue already holds QDEPTH entries is dropped, and no entry is created.
- R5: When an operate's address is accepted and one of its sources (bits [20:16] or [15:11]) equals the destination (bits [25:21]) of a queued, uncompleted non-compare operate, hold_n is 0 in the next cycle. With no match, hold_n stays 1.
- R6: hold_n stays 0 while the producer executes, and it returns to 1 after the producer completes.
- R7: cc_valid goes to 0 in the cycle after a compare (class 10, opcode 0) is accepted. It returns to 1 when that compare completes, and cc then holds the value dp_cc had at completion (00 equal, 01 less, 10 greater, 11 unordered).
- R8: An exception raised by dp_exc at completion is held pending. exc_req_n goes to 0 only in the cycle after an ins_strobe whose bus word has a class other than 00. A class-00 strobe does not signal it.
- R9: exc_req_n stays 0 until exc_ack is seen, and it is 1 in the cycle after the acknowledge.
- R10: flush empties both queues, releases the hold, cancels the executing operation and discards a pending, unsignalled exception. A floating-point ins_strobe in the same cycle does not signal the exception.
- R11: Branch and load/store entries complete on entry, so consecutive end_strobes retire them one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 32 | Shared instruction/address bus |
| ins_strobe | input | 1 | Bus carries an instruction |
| adr_strobe | input | 1 | Bus carries the address of the latched instruction |
| end_strobe | input | 1 | Host pipeline end of instruction |
| flush | input | 1 | Discard all queued and pending state |
| exc_ack | input | 1 | Host acknowledges the exception request |
| dp_cc | input | 2 | Condition code produced by the modelled datapath |
| dp_exc | input | 1 | Exception flag produced by the modelled datapath |
| hold_n | output | 1 | Active-low dependency hold |
| exc_req_n | output | 1 | Active-low exception request |
| cc | output | 2 | Condition codes |
| cc_valid | output | 1 | Condition codes are meaningful |
| head_valid | output | 1 | Queue holds at least one entry |
| head_addr | output | 32 | Address of the oldest queued entry |

## Verification
Two events can fall in the same cycle: a flush, and a floating-point instruction strobe that would otherwise turn a pending exception into a request. The bench lets a faulting operate complete, so that the exception is pending. It then raises flush and a load/store instruction strobe on the same edge. The result is correct only if exc_req_n stays high in that cycle and after a later floating-point strobe, and if the queue reads empty at the same time. Hold release against producer completion is judged separately: the hold must still be low one cycle after it is raised, and it must go high within a bounded window.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int BUS_W = 32;
  localparam int REG_W = 5;
  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_CMP = '0;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'b00,
    CLS_BRANCH = 2'b01,
    CLS_OPER   = 2'b10,
    CLS_MEM    = 2'b11
  } ins_class_e;

  function automatic ins_class_e cls_of(input logic [BUS_W-1:0] w);
    return ins_class_e'(w[31:30]);
  endfunction

  function automatic logic [OPC_W-1:0] opc_of(input logic [BUS_W-1:0] w);
    return w[29:26];
  endfunction

  function automatic logic [REG_W-1:0] dst_of(input logic [BUS_W-1:0] w);
    return w[25:21];
  endfunction

  function automatic logic is_cmp(input logic [BUS_W-1:0] w);
    return cls_of(w) == CLS_OPER && opc_of(w) == OPC_CMP;
  endfunction

  function automatic logic is_producer(input logic [BUS_W-1:0] w);
    return cls_of(w) == CLS_OPER && opc_of(w) != OPC_CMP;
  endfunction

  function automatic logic src_hit(input logic [BUS_W-1:0] w, input logic [REG_W-1:0] r);
    return cls_of(w) == CLS_OPER && (w[20:16] == r || w[15:11] == r);
  endfunction
endpackage

// File: rtl/fpc_queue.sv
module fpc_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 din,
  output logic [DEPTH-1:0][W-1:0]      slots,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] wr_idx;
  assign wr_idx = count - CW'(pop);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_idx == CW'(g))
        slots[g] <= din;
      else if (pop && g < DEPTH-1)
        slots[g] <= slots[(g < DEPTH-1) ? g+1 : g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else            count <= count - CW'(pop) + CW'(push);
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= DEPTH);
  assert_no_pop_empty_R3: assert property (@(posedge clk) disable iff (rst)
    pop |-> count != '0);
endmodule

// File: rtl/fpc_exec.sv
module fpc_exec #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic kill,
  input  logic start,
  output logic busy,
  output logic fin
);
  localparam int CW = $clog2(LAT+1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      busy <= 1'b0;
      fin  <= 1'b0;
      cnt  <= '0;
    end else begin
      fin <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(LAT-1);
      end
    end
  end

  assert_fin_single_R6: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);
endmodule

// File: rtl/fpc_handshake.sv
module fpc_handshake
  import fpc_pkg::*;
#(
  parameter int QDEPTH = 2,
  parameter int LAT    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      bus_data,
  input  logic             ins_strobe,
  input  logic             adr_strobe,
  input  logic             end_strobe,
  input  logic             flush,
  input  logic             exc_ack,
  input  logic [1:0]       dp_cc,
  input  logic             dp_exc,
  output logic             hold_n,
  output logic             exc_req_n,
  output logic [1:0]       cc,
  output logic             cc_valid,
  output logic             head_valid,
  output logic [31:0]      head_addr
);
  localparam int CW = $clog2(QDEPTH+1);
  localparam int IW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  logic [BUS_W-1:0]              ins_reg;
  logic                          ins_pend;
  logic [QDEPTH-1:0][BUS_W-1:0]  iq, aq;
  logic [CW-1:0]                 icount, acount;
  logic [QDEPTH-1:0]             done;
  logic [IW-1:0]                 hold_slot;
  logic                          push_ok, pop_ok, start, busy, fin;
  logic                          dep_new, dep_held, exc_pend;
  logic [CW-1:0]                 wr_idx;

  assign pop_ok  = end_strobe && !flush && icount != '0 && done[0];
  assign wr_idx  = icount - CW'(pop_ok);
  assign push_ok = adr_strobe && ins_pend && !flush && int'(wr_idx) < QDEPTH;
  assign start   = !busy && !fin && !flush && icount != '0 &&
                   cls_of(iq[0]) == CLS_OPER && !done[0];

  fpc_queue #(.W(BUS_W), .DEPTH(QDEPTH)) u_iq (
    .clk(clk), .rst(rst), .clr(flush), .push(push_ok), .pop(pop_ok),
    .din(ins_reg), .slots(iq), .count(icount));

  fpc_queue #(.W(BUS_W), .DEPTH(QDEPTH)) u_aq (
    .clk(clk), .rst(rst), .clr(flush), .push(push_ok), .pop(pop_ok),
    .din(bus_data), .slots(aq), .count(acount));

  fpc_exec #(.LAT(LAT)) u_exec (
    .clk(clk), .rst(rst), .kill(flush), .start(start), .busy(busy), .fin(fin));

  assign head_valid = acount != '0;
  assign head_addr  = aq[0];

  // instruction register
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ins_pend <= 1'b0;
      ins_reg  <= '0;
    end else if (ins_strobe) begin
      ins_pend <= 1'b1;
      ins_reg  <= bus_data;
    end else if (push_ok) begin
      ins_pend <= 1'b0;
    end
  end

  // completion state per queue slot
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      done <= '0;
    end else begin
      for (int i = 0; i < QDEPTH; i++) begin
        if (push_ok && int'(wr_idx) == i)
          done[i] <= cls_of(ins_reg) != CLS_OPER;
        else if (pop_ok)
          done[i] <= (i < QDEPTH-1) ? done[(i < QDEPTH-1) ? i+1 : i] : 1'b0;
        else if (fin && i == 0)
          done[i] <= 1'b1;
      end
    end
  end

  // dependency detection
  always_comb begin
    dep_new  = 1'b0;
    dep_held = 1'b0;
    for (int i = 0; i < QDEPTH; i++) begin
      if (i < int'(icount) && is_producer(iq[i]) && !done[i] &&
          src_hit(ins_reg, dst_of(iq[i])))
        dep_new = 1'b1;
      if (i < int'(hold_slot) && is_producer(iq[i]) && !done[i] &&
          src_hit(iq[hold_slot], dst_of(iq[i])))
        dep_held = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hold_n    <= 1'b1;
      hold_slot <= '0;
    end else if (push_ok) begin
      hold_n    <= !dep_new;
      hold_slot <= IW'(wr_idx);
    end else if (!hold_n) begin
      hold_n    <= !dep_held;
      if (pop_ok && hold_slot != '0) hold_slot <= hold_slot - 1'b1;
    end
  end

  // condition codes
  always_ff @(posedge clk) begin
    if (rst) begin
      cc       <= 2'b00;
      cc_valid <= 1'b1;
    end else if (flush) begin
      cc_valid <= 1'b1;
    end else begin
      if (fin && is_cmp(iq[0])) begin
        cc       <= dp_cc;
        cc_valid <= 1'b1;
      end
      if (push_ok && is_cmp(ins_reg)) cc_valid <= 1'b0;
    end
  end

  // exception handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      exc_req_n <= 1'b1;
      exc_pend  <= 1'b0;
    end else begin
      if (!exc_req_n && exc_ack) exc_req_n <= 1'b1;
      if (exc_pend && exc_req_n && ins_strobe && !flush &&
          cls_of(bus_data) != CLS_NONE) begin
        exc_req_n <= 1'b0;
        exc_pend  <= 1'b0;
      end
      if (fin && dp_exc) exc_pend <= 1'b1;
      if (flush)         exc_pend <= 1'b0;
    end
  end

  assert_hold_on_addr_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_n) |-> $past(adr_strobe));
  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (hold_n && !head_valid));
  assert_req_held_R9: assert property (@(posedge clk) disable iff (rst)
    (!exc_req_n && !exc_ack) |=> !exc_req_n);
  assert_req_on_fp_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(exc_req_n) |-> ($past(ins_strobe) && $past(bus_data[31:30]) != 2'b00));
  assert_ccv_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(cc_valid) |-> ($past(fin) || $past(flush)));
endmodule

// File: tb/sim_fpc_handshake.sv
module sim_fpc_handshake;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_data = '0;
  logic        ins_strobe = 0, adr_strobe = 0, end_strobe = 0, flush = 0, exc_ack = 0;
  logic [1:0]  dp_cc = 2'b00;
  logic        dp_exc = 0;
  logic        hold_n, exc_req_n, cc_valid, head_valid;
  logic [1:0]  cc;
  logic [31:0] head_addr;
  int          tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpc_handshake u0 (
    .clk(clk), .rst(rst), .bus_data(bus_data), .ins_strobe(ins_strobe),
    .adr_strobe(adr_strobe), .end_strobe(end_strobe), .flush(flush),
    .exc_ack(exc_ack), .dp_cc(dp_cc), .dp_exc(dp_exc), .hold_n(hold_n),
    .exc_req_n(exc_req_n), .cc(cc), .cc_valid(cc_valid),
    .head_valid(head_valid), .head_addr(head_addr));

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_op(input logic [3:0] op, input logic [4:0] rd, input logic [4:0] s1, input logic [4:0] s2);
    return {2'b10, op, rd, s1, s2, 11'h0};
  endfunction
  localparam logic [31:0] MEM_INS = {2'b11, 30'h155};
  localparam logic [31:0] BR_INS  = {2'b01, 30'h2};
  localparam logic [31:0] NFP_INS = {2'b00, 30'h7};

  task automatic send(input logic [31:0] ins, input logic [31:0] adr);
    bus_data = ins; ins_strobe = 1; cyc();
    ins_strobe = 0; bus_data = adr; adr_strobe = 1; cyc();
    adr_strobe = 0; bus_data = '0;
  endtask

  task automatic drain();
    end_strobe = 1;
    repeat (30) cyc();
    end_strobe = 0;
  endtask

  task automatic t_reset();
    check(hold_n == 1,    "R1 hold_n", hold_n, 1);
    check(exc_req_n == 1, "R1 exc_req_n", exc_req_n, 1);
    check(cc_valid == 1,  "R1 cc_valid", cc_valid, 1);
    check(cc == 2'b00,    "R1 cc", cc, 0);
    check(head_valid == 0,"R1 head_valid", head_valid, 0);
  endtask

  task automatic t_queue();
    send(MEM_INS, 32'h100);
    check(head_valid == 1 && head_addr == 32'h100, "R2 first head", head_addr, 32'h100);
    send(BR_INS, 32'h104);
    check(head_addr == 32'h100, "R2 second waits", head_addr, 32'h100);
    end_strobe = 1; cyc();
    check(head_addr == 32'h104, "R11 mem retired", head_addr, 32'h104);
    cyc(); end_strobe = 0;
    check(head_valid == 0, "R11 branch retired", head_valid, 0);
  endtask

  task automatic t_retire_gate();
    send(mk_op(4'h1, 5'd1, 5'd2, 5'd3), 32'h200);
    end_strobe = 1; cyc(); end_strobe = 0;
    check(head_valid == 1 && head_addr == 32'h200, "R3 early end ignored", head_addr, 32'h200);
    repeat (LAT_WAIT) cyc();
    end_strobe = 1; cyc(); end_strobe = 0;
    check(head_valid == 0, "R3 end after completion", head_valid, 0);
  endtask
  localparam int LAT_WAIT = 10;

  task automatic t_full();
    send(MEM_INS, 32'h300);
    send(MEM_INS, 32'h304);
    send(MEM_INS, 32'h308);
    end_strobe = 1; cyc();
    check(head_valid == 1 && head_addr == 32'h304, "R4 second entry", head_addr, 32'h304);
    cyc(); end_strobe = 0;
    check(head_valid == 0, "R4 third dropped", head_valid, 0);
  endtask

  task automatic t_hold();
    bit rel = 0;
    send(mk_op(4'h1, 5'd3, 5'd1, 5'd2), 32'h400);
    send(mk_op(4'h2, 5'd4, 5'd3, 5'd9), 32'h404);
    check(hold_n == 0, "R5 hold on match", hold_n, 0);
    cyc();
    check(hold_n == 0, "R6 hold kept while busy", hold_n, 0);
    for (int i = 0; i < 20; i++) begin
      if (hold_n) rel = 1;
      if (!rel) cyc();
    end
    check(rel, "R6 hold released", hold_n, 1);
    drain();
    send(mk_op(4'h1, 5'd5, 5'd1, 5'd2), 32'h410);
    send(mk_op(4'h1, 5'd8, 5'd6, 5'd7), 32'h414);
    check(hold_n == 1, "R5 no hold without match", hold_n, 1);
    drain();
  endtask

  task automatic t_cc(input logic [1:0] v);
    bit seen = 0;
    dp_cc = v;
    send(mk_op(4'h0, 5'd0, 5'd1, 5'd2), 32'h500);
    check(cc_valid == 0, "R7 valid low after compare", cc_valid, 0);
    for (int i = 0; i < 20; i++) begin
      if (cc_valid) seen = 1;
      if (!seen) cyc();
    end
    check(seen && cc == v, "R7 codes at completion", {30'h0, cc}, {30'h0, v});
    drain();
  endtask

  task automatic t_exc();
    dp_exc = 1;
    send(mk_op(4'h1, 5'd10, 5'd11, 5'd12), 32'h600);
    repeat (10) cyc();
    dp_exc = 0;
    check(exc_req_n == 1, "R8 not signalled without FP strobe", exc_req_n, 1);
    bus_data = NFP_INS; ins_strobe = 1; cyc(); ins_strobe = 0;
    check(exc_req_n == 1, "R8 non-FP strobe ignored", exc_req_n, 1);
    bus_data = MEM_INS; ins_strobe = 1; cyc(); ins_strobe = 0;
    check(exc_req_n == 0, "R8 signalled on FP strobe", exc_req_n, 0);
    repeat (3) cyc();
    check(exc_req_n == 0, "R9 held until ack", exc_req_n, 0);
    exc_ack = 1; cyc(); exc_ack = 0;
    check(exc_req_n == 1, "R9 released after ack", exc_req_n, 1);
    drain();
  endtask

  task automatic t_flush();
    send(mk_op(4'h1, 5'd9, 5'd1, 5'd2), 32'h700);
    send(mk_op(4'h1, 5'd4, 5'd9, 5'd2), 32'h704);
    check(hold_n == 0, "R10 hold before flush", hold_n, 0);
    flush = 1; cyc(); flush = 0;
    check(hold_n == 1 && head_valid == 0, "R10 flush clears hold and queue", {hold_n, head_valid}, 2'b10);
    dp_exc = 1;
    send(mk_op(4'h1, 5'd8, 5'd1, 5'd2), 32'h710);
    repeat (10) cyc();
    dp_exc = 0;
    bus_data = MEM_INS; ins_strobe = 1; flush = 1; cyc();
    ins_strobe = 0; flush = 0;
    check(exc_req_n == 1 && head_valid == 0, "R10 flush beats FP strobe", {exc_req_n, head_valid}, 2'b10);
    bus_data = MEM_INS; ins_strobe = 1; cyc(); ins_strobe = 0;
    check(exc_req_n == 1, "R10 pending exception discarded", exc_req_n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    t_reset();
    t_queue();
    t_retire_gate();
    t_full();
    t_hold();
    t_cc(2'b10);
    t_cc(2'b11);
    t_exc();
    t_flush();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule